// File: doc/BRIEF.md
# CPU/Video DRAM Slot Arbiter

This block shares one multiplexed-address DRAM between a processor and a display fetch engine. The memory is accessed in fixed time slots of four clock ticks each. The slots run in strict rotation: processor, video, processor, video. With a slot clock that gives 250 ns slots, the DRAM sees a 4 MHz access rate. Each microsecond then holds two processor slots and two display slots, so a 2 MHz processor always finds exactly one slot per bus cycle. Ownership never changes at run time. A processor slot with nothing pending stays quiet. A display slot is never lent to the processor.

Every display slot performs a full row strobe at the display address. Because the display engine walks steadily through memory, these strobes also keep every DRAM row refreshed, and the block needs no refresh counter or refresh cycle of its own. Within a slot, the low half of the word address goes out first as the row with the row strobe. The high half then follows as the column with the column strobe. A one-tick data-valid pulse tells the slot's owner that its access is complete.

Top module: `dram_slot_arbiter`

## Requirements
- R1: After reset, the block is in phase 0 of a processor slot with no access under way. All strobes are high and both acknowledges are low. The phase advances by one every clock, and every slot is four clocks long. Slot ownership alternates processor, video, processor, video, and the first slot after reset belongs to the processor.
- R2: The processor request, write flag and address are sampled on the clock edge that ends the video slot just before a processor slot. The access uses only the sampled values.
- R3: During an active slot, dram_addr carries the row, which is the low ROW_W address bits, in phase 0. It carries the column, which is the high ROW_W bits, in phases 1 to 3. ras_n is low in phases 0 to 2. cas_n is low in phases 1 and 2 only.
- R4: A processor slot whose sampled request was low keeps ras_n, cas_n and we_n high for all four phases and gives no cpu_ack.
- R5: we_n is low only in phases 1 and 2 of a processor slot whose sampled request was a write. It is high at every other time.
- R6: cpu_ack pulses for exactly the phase-3 clock of each served processor slot. vid_ack pulses for exactly the phase-3 clock of every video slot. The two are never high together.
- R7: Every video slot performs a read strobe cycle (row and column) at vid_addr, sampled on the edge that ends the preceding processor slot. It never drives we_n low and never raises cpu_ack.
- R8: As long as the display address steps through all row values often enough, every DRAM row is strobed at least once in each refresh window of REFRESH_CLKS clocks. These display strobes are the only refresh the DRAM receives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot phase clock, four ticks per slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor wants an access in its next slot |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | ADDR_W | Processor word address (row in the low half, column in the high half) |
| vid_addr | input | ADDR_W | Display fetch address |
| dram_addr | output | ROW_W | Multiplexed row/column address to the DRAM |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |
| cpu_ack | output | 1 | Processor data-valid pulse at the end of its slot |
| vid_ack | output | 1 | Display data-valid pulse at the end of its slot |

## Verification
The refresh property depends on one assumption about the inputs: the display address must pass through every row value within one refresh window. The block only guarantees refresh if that holds. The stimulus meets it by advancing the low half of vid_addr once per video slot, which covers all rows in half a window. The high half is randomised. The assertions also rely on the processor inputs being stable around the sampling edge. The bench drives them on the falling clock. Processor requests, write flags and addresses are random, with directed stretches of idle slots, all-write slots and the extreme addresses all-zeros and all-ones.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;

    // Clock ticks in one DRAM slot, and slots in one rotation.
    localparam int SLOT_PHASES = 4;
    localparam int ROT_SLOTS   = 4;
    localparam int PH_W        = $clog2(SLOT_PHASES);
    localparam int SLOT_W      = $clog2(ROT_SLOTS);

    // Phase windows inside a slot.
    localparam int RAS_LAST_PH = SLOT_PHASES - 2;
    localparam int CAS_FIRST_PH = 1;
    localparam int CAS_LAST_PH = SLOT_PHASES - 2;
    localparam int DONE_PH     = SLOT_PHASES - 1;

    typedef enum logic {
        OWN_CPU = 1'b0,
        OWN_VID = 1'b1
    } owner_e;

    typedef struct packed {
        logic [PH_W-1:0]   ph;
        logic [SLOT_W-1:0] slot;
    } seq_t;

    typedef struct packed {
        logic   act;
        logic   wr;
        owner_e own;
    } slot_ctl_t;

    // Even slots belong to the processor, odd slots to the display.
    function automatic owner_e owner_of(input logic [SLOT_W-1:0] s);
        return s[0] ? OWN_VID : OWN_CPU;
    endfunction

endpackage

// File: rtl/dram_slot_seq.sv
module dram_slot_seq
    import dram_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [PH_W-1:0]   ph_q,
    output logic [SLOT_W-1:0] slot_q,
    output logic              slot_end,
    output owner_e            next_own
);

    seq_t seq_d, seq_r;

    always_comb begin
        seq_d    = seq_r;
        slot_end = (seq_r.ph == PH_W'(DONE_PH));
        seq_d.ph = seq_r.ph + PH_W'(1);
        if (slot_end) begin
            seq_d.slot = seq_r.slot + SLOT_W'(1);
        end
        next_own = owner_of(seq_r.slot + SLOT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_r <= '0;
        end else begin
            seq_r <= seq_d;
        end
    end

    assign ph_q   = seq_r.ph;
    assign slot_q = seq_r.slot;

endmodule

// File: rtl/dram_slot_latch.sv
module dram_slot_latch
    import dram_arb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_end,
    input  owner_e            next_own,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [ADDR_W-1:0] vid_addr,
    output slot_ctl_t         ctl_q,
    output logic [ADDR_W-1:0] addr_q
);

    typedef struct packed {
        slot_ctl_t         ctl;
        logic [ADDR_W-1:0] addr;
    } latch_t;

    latch_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (slot_end) begin
            if (next_own == OWN_CPU) begin
                lat_d.ctl.act = cpu_req;
                lat_d.ctl.wr  = cpu_req & cpu_we;
                lat_d.ctl.own = OWN_CPU;
                lat_d.addr    = cpu_addr;
            end else begin
                // Display fetches always run: they are the refresh.
                lat_d.ctl.act = 1'b1;
                lat_d.ctl.wr  = 1'b0;
                lat_d.ctl.own = OWN_VID;
                lat_d.addr    = vid_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q.ctl.act <= 1'b0;
            lat_q.ctl.wr  <= 1'b0;
            lat_q.ctl.own <= OWN_CPU;
            lat_q.addr    <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign ctl_q  = lat_q.ctl;
    assign addr_q = lat_q.addr;

endmodule

// File: rtl/dram_strobe_gen.sv
module dram_strobe_gen
    import dram_arb_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int ADDR_W = 2 * ROW_W
) (
    input  logic [PH_W-1:0]   ph,
    input  slot_ctl_t         ctl,
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  dram_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cpu_ack,
    output logic              vid_ack
);

    logic ras_win, cas_win, done_win;
    logic [ROW_W-1:0] row_part, col_part;

    always_comb begin
        ras_win  = (ph <= PH_W'(RAS_LAST_PH));
        cas_win  = (ph >= PH_W'(CAS_FIRST_PH)) && (ph <= PH_W'(CAS_LAST_PH));
        done_win = (ph == PH_W'(DONE_PH));

        row_part = addr[ROW_W-1:0];
        col_part = addr[ADDR_W-1:ROW_W];

        dram_addr = (ph == '0) ? row_part : col_part;
        ras_n     = ~(ctl.act & ras_win);
        cas_n     = ~(ctl.act & cas_win);
        we_n      = ~(ctl.act & ctl.wr & cas_win);
        cpu_ack   = ctl.act & done_win & (ctl.own == OWN_CPU);
        vid_ack   = ctl.act & done_win & (ctl.own == OWN_VID);
    end

endmodule

// File: rtl/dram_slot_arbiter.sv
module dram_slot_arbiter
    import dram_arb_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int ADDR_W = 2 * ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [ADDR_W-1:0] vid_addr,
    output logic [ROW_W-1:0]  dram_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cpu_ack,
    output logic              vid_ack
);

    logic [PH_W-1:0]   ph_q;
    logic [SLOT_W-1:0] slot_q;
    logic              slot_end;
    owner_e            next_own;
    slot_ctl_t         ctl_q;
    logic [ADDR_W-1:0] addr_q;

    dram_slot_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph_q     (ph_q),
        .slot_q   (slot_q),
        .slot_end (slot_end),
        .next_own (next_own)
    );

    dram_slot_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_end (slot_end),
        .next_own (next_own),
        .cpu_req  (cpu_req),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .vid_addr (vid_addr),
        .ctl_q    (ctl_q),
        .addr_q   (addr_q)
    );

    dram_strobe_gen #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_strobe (
        .ph        (ph_q),
        .ctl       (ctl_q),
        .addr      (addr_q),
        .dram_addr (dram_addr),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .cpu_ack   (cpu_ack),
        .vid_ack   (vid_ack)
    );

endmodule

// File: rtl/dram_slot_arbiter_chk.sv
module dram_slot_arbiter_chk
    import dram_arb_pkg::*;
#(
    parameter int ROW_W        = 8,
    parameter int REFRESH_CLKS = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PH_W-1:0]   ph,
    input logic [SLOT_W-1:0] slot,
    input logic [ROW_W-1:0]  dram_addr,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              cpu_ack,
    input logic              vid_ack
);

    localparam int ROWS  = 1 << ROW_W;
    localparam int WIN_W = $clog2(REFRESH_CLKS);

    logic [WIN_W-1:0] win_q;
    logic [ROWS-1:0]  seen_q;
    logic [ROWS-1:0]  seen_now;
    logic             win_end;

    always_comb begin
        seen_now = seen_q;
        if (ph == '0 && !ras_n) begin
            seen_now[dram_addr] = 1'b1;
        end
        win_end = (win_q == WIN_W'(REFRESH_CLKS - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            seen_q <= '0;
        end else begin
            win_q  <= win_end ? '0 : win_q + WIN_W'(1);
            seen_q <= win_end ? '0 : seen_now;
        end
    end

    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ph == $past(ph) + PH_W'(1));
    p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ph == PH_W'(DONE_PH) |=> slot == $past(slot) + SLOT_W'(1));
    p_slot_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ph != PH_W'(DONE_PH) |=> $stable(slot));
    p_cas_in_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);
    p_ras_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ph == '0 && cas_n);
    p_idle_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot[0] && ph == '0 && ras_n) |=> ras_n && cas_n && we_n);
    p_we_in_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cas_n && !slot[0]);
    p_ack_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack || vid_ack) |-> ph == PH_W'(DONE_PH));
    p_ack_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cpu_ack, vid_ack}) <= 1);
    p_vid_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot[0] && ph != PH_W'(DONE_PH)) |-> !ras_n && we_n && !cpu_ack);
    p_refresh_sweep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> &seen_now);

endmodule

bind dram_slot_arbiter dram_slot_arbiter_chk #(.ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph        (ph_q),
    .slot      (slot_q),
    .dram_addr (dram_addr),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .cpu_ack   (cpu_ack),
    .vid_ack   (vid_ack)
);

// File: tb/dram_slot_arbiter_test.sv
`timescale 1ns/1ps
module dram_slot_arbiter_test;

    localparam int ROW_W  = 8;
    localparam int ADDR_W = 16;
    localparam int WINDOW = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0, vid_addr = '0;
    logic [ROW_W-1:0]  dram_addr;
    logic              ras_n, cas_n, we_n, cpu_ack, vid_ack;

    int checks = 0, fails = 0;
    bit finished = 0;

    // Reference model state
    int          m_ph = 0, m_slot = 0, vcnt = 0, cyc = 0;
    bit          m_act = 0, m_wr = 0, m_vid = 0;
    logic [15:0] m_addr = '0;
    bit [255:0]  rows_seen = '0;

    always #5 clk = ~clk;

    dram_slot_arbiter #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .vid_addr(vid_addr), .dram_addr(dram_addr),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cpu_ack(cpu_ack), .vid_ack(vid_ack));

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic bit f_ras(bit a, int p);  return !(a && p <= 2); endfunction
    function automatic bit f_cas(bit a, int p);  return !(a && (p == 1 || p == 2)); endfunction
    function automatic bit f_we(bit a, bit w, int p); return !(a && w && (p == 1 || p == 2)); endfunction
    function automatic logic [7:0] f_mux(logic [15:0] a, int p); return (p == 0) ? a[7:0] : a[15:8]; endfunction

    // Advance the model by one edge using the inputs present at that edge.
    task automatic step();
        bit          s_req = cpu_req, s_we = cpu_we;
        logic [15:0] s_ca = cpu_addr, s_va = vid_addr;
        string       tag;
        @(posedge clk);
        #1;
        cyc++;
        if (m_ph == 3) begin
            m_slot = (m_slot + 1) % 4;
            if (m_slot % 2 == 0) begin       // R2: sampled at end of video slot
                m_act = s_req; m_wr = s_req && s_we; m_vid = 0; m_addr = s_ca;
            end else begin                   // R7: sampled at end of processor slot
                m_act = 1; m_wr = 0; m_vid = 1; m_addr = s_va;
            end
        end
        m_ph = (m_ph + 1) % 4;
        tag = m_vid ? "R7" : (m_act ? "R3" : "R4");
        check(ras_n == f_ras(m_act, m_ph), {tag, " ras_n"}, 16'(ras_n), 16'(f_ras(m_act, m_ph)));
        check(cas_n == f_cas(m_act, m_ph), {tag, " cas_n"}, 16'(cas_n), 16'(f_cas(m_act, m_ph)));
        check(we_n == f_we(m_act, m_wr, m_ph), "R5 we_n", 16'(we_n), 16'(f_we(m_act, m_wr, m_ph)));
        check(cpu_ack == (m_act && !m_vid && m_ph == 3), "R6 cpu_ack", 16'(cpu_ack), 16'(m_act && !m_vid && m_ph == 3));
        check(vid_ack == (m_vid && m_ph == 3), "R6 vid_ack", 16'(vid_ack), 16'(m_vid && m_ph == 3));
        if (m_act)
            check(dram_addr == f_mux(m_addr, m_ph), m_vid ? "R7 vid addr" : "R2 cpu addr",
                  16'(dram_addr), 16'(f_mux(m_addr, m_ph)));
        if (!ras_n && m_ph == 0) rows_seen[dram_addr] = 1'b1;
        if (cyc % WINDOW == 0) begin          // R8 refresh window
            check(&rows_seen, "R8 rows strobed", 16'($countones(rows_seen)), 16'd256);
            rows_seen = '0;
        end
    endtask

    // mode: 0 random, 1 idle, 2 writes at extreme addresses
    task automatic run(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vcnt++;
            vid_addr = {8'($urandom), 8'(vcnt >> 3)};
            case (mode)
                1: begin cpu_req = 0; cpu_we = 1'($urandom); cpu_addr = 16'($urandom); end
                2: begin cpu_req = 1; cpu_we = 1; cpu_addr = (i / 16) % 2 ? 16'hFFFF : 16'h0000; end
                default: begin
                    cpu_req = ($urandom % 4) != 0; cpu_we = 1'($urandom); cpu_addr = 16'($urandom);
                end
            endcase
            step();
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0D1A));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(ras_n && cas_n && we_n, "R1 reset strobes", {13'd0, ras_n, cas_n, we_n}, 16'h7);
        check(!cpu_ack && !vid_ack, "R1 reset acks", {14'd0, cpu_ack, vid_ack}, 16'h0);
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = 16'hA55A;
        rst_n = 1;
        // R1: first slot after reset is an idle processor slot regardless of inputs
        step();
        run(1200, 0);
        run(400, 1);
        run(400, 2);
        run(4200, 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule